// File: doc/BRIEF.md
# Configurable asynchronous serial channel

This block is one full-duplex asynchronous serial channel: a transmitter and a receiver that share a serial clock enable. Software-visible configuration is left outside; the channel takes four run-time configuration fields as plain inputs. These are character length, stop-bit count, parity mode and clock-rate multiplier. Bytes written on the parallel side are framed and shifted out on `txd`. Frames arriving on `rxd` are unpacked into characters, and each character carries its own error flags through a four-entry receive queue to the read side. The transmitter can hold the line low as a break, and the receiver recognises and reports an incoming break.

The transmitter is a state machine with the states IDLE, START, DATA, PAR, STOP and BRK. The transitions are:
- IDLE to START when a byte is pending.
- IDLE to BRK when a break is requested.
- START to DATA after one bit time.
- DATA to PAR, or DATA to STOP when parity is off, after the last data bit.
- PAR to STOP after one bit time.
- STOP to START when a further byte is already pending.
- STOP to BRK when a break is requested.
- STOP to IDLE otherwise.
- BRK to IDLE when the break request is released.

Every transition of the transmitter happens on a serial clock enable pulse.

The receiver is a state machine with the states HUNT, START, DATA, PAR, STOP and WAIT. The transitions are:
- HUNT to START when a low is seen in an oversampled mode.
- HUNT to DATA when a low is seen in x1 mode.
- START to DATA when the low is confirmed at mid-bit.
- START to HUNT when the low was a glitch.
- DATA to PAR or to STOP after the last data bit.
- PAR to STOP after the parity bit.
- STOP to HUNT on a good stop bit.
- STOP to WAIT on a bad stop bit.
- WAIT to HUNT once the line is seen high.

The receiver samples its synchronised input only on enable pulses.

Top module: `async_serial_chan`

## Requirements
- R1: After reset `txd` is high, `tx_ready` is high and `rx_valid` is low.
- R2: A transmitted frame is one low start bit, then the data bits least-significant first, then the optional parity bit, then a high stop period. `cfg_len` values 0, 1, 2 and 3 select 5, 6, 7 and 8 data bits. `txd` changes only in the cycle after a cycle with `sclk_en` high.
- R3: The parity field is set by `cfg_par`: 0 means no parity, 1 means even and 2 means odd. With parity on, the transmitter appends the parity bit over the data bits. The receiver raises `rx_perr` on a character whose parity bit disagrees.
- R4: `cfg_stop` values 0, 1 and 2 give 1, 1.5 and 2 stop bits. In x1 mode, 1.5 stop bits take two bit times. With back-to-back frames, the high time between frames is exactly the stop period.
- R5: `cfg_mult` values 0, 1, 2 and 3 set one bit time to 1, 16, 32 or 64 `sclk_en` pulses, for both directions.
- R6: An accepted write makes `tx_ready` go low on the next cycle. `tx_ready` rises again only on an enable pulse, when the byte moves to the shift register at the start of its frame. A write while `tx_ready` is low is ignored.
- R7: In the oversampled modes, a low on `rxd` that is gone by mid-bit of the start bit produces no character.
- R8: Received data bits are assembled least-significant first. For characters shorter than 8 bits, the unused upper bits of `rx_data` read as zero.
- R9: A character whose first stop bit is low has `rx_ferr` set. The receiver then waits for the line to go high before it looks for a new start bit.
- R10: The receive queue holds up to four characters in arrival order. The oldest character is shown while `rx_valid` is high, stays stable until `rx_rd`, and `rx_rd` removes it.
- R11: A character that completes while all four entries are full is discarded, and `rx_ovr` is set on the newest stored entry.
- R12: A received all-zero character with zero parity bit (if any) and a low stop bit produces one entry with `rx_brk` and `rx_ferr` set and data zero. No further entry follows while the line stays low.
- R13: `tx_break` high makes the transmitter hold `txd` low once any frame in progress has ended. When `tx_break` is released, `txd` returns high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sclk_en | input | 1 | Serial clock enable pulse, 1/16/32/64 per bit |
| cfg_len | input | 2 | Data bits: 0=5, 1=6, 2=7, 3=8 |
| cfg_stop | input | 2 | Stop bits: 0=1, 1=1.5, 2=2 |
| cfg_par | input | 2 | Parity: 0=none, 1=even, 2=odd |
| cfg_mult | input | 2 | Enable pulses per bit: 0=1, 1=16, 2=32, 3=64 |
| tx_data | input | 8 | Byte to transmit |
| tx_wr | input | 1 | Write strobe for `tx_data` |
| tx_break | input | 1 | Hold line in break |
| tx_ready | output | 1 | Holding register empty |
| txd | output | 1 | Serial output |
| rxd | input | 1 | Serial input |
| rx_rd | input | 1 | Remove oldest received entry |
| rx_valid | output | 1 | Receive queue not empty |
| rx_data | output | 8 | Oldest received character |
| rx_perr | output | 1 | Parity error of that character |
| rx_ferr | output | 1 | Framing error of that character |
| rx_ovr | output | 1 | Overrun marked on that character |
| rx_brk | output | 1 | Character is a break |

## Verification
The transmitter is tried with distinct bytes in 8-bit no-parity x1, 7-bit even x16 and 5-bit odd x32 formats. These separate bit order, length masking and parity sense. Back-to-back all-zero bytes make the stop period the only high time, so 1, 1.5 and 2 stop bits are told apart by the exact gap length. The receiver gets clean frames in x16, x32 and x64 with different lengths, where a 5-bit all-ones frame shows upper-bit masking. Corrupted parity, a low stop bit, a short glitch, a long low line and five unread frames each isolate one error path from the clean path.

// File: rtl/async_serial_pkg.sv
package async_serial_pkg;

    localparam int DATA_W = 8;
    localparam int CNT_W  = 8;

    localparam logic [1:0] PAR_NONE = 2'd0;
    localparam logic [1:0] PAR_EVEN = 2'd1;
    localparam logic [1:0] PAR_ODD  = 2'd2;

    typedef enum logic [2:0] {
        T_IDLE, T_START, T_DATA, T_PAR, T_STOP, T_BRK
    } tx_state_e;

    typedef enum logic [2:0] {
        R_HUNT, R_START, R_DATA, R_PAR, R_STOP, R_WAIT
    } rx_state_e;

    typedef struct packed {
        logic [DATA_W-1:0] data;
        logic              perr;
        logic              ferr;
        logic              brk;
        logic              ovr;
    } rx_entry_t;

    function automatic logic [CNT_W-1:0] bit_ticks(input logic [1:0] mult);
        case (mult)
            2'd0:    return CNT_W'(1);
            2'd1:    return CNT_W'(16);
            2'd2:    return CNT_W'(32);
            default: return CNT_W'(64);
        endcase
    endfunction

    function automatic logic [CNT_W-1:0] stop_ticks(input logic [1:0] mult,
                                                    input logic [1:0] stop);
        logic [CNT_W-1:0] bt;
        bt = bit_ticks(mult);
        case (stop)
            2'd0:    return bt;
            2'd1:    return (mult == 2'd0) ? CNT_W'(2) : bt + (bt >> 1);
            default: return bt << 1;
        endcase
    endfunction

    function automatic logic [2:0] last_bit(input logic [1:0] len);
        return {1'b0, len} + 3'd4;
    endfunction

    function automatic logic [DATA_W-1:0] len_mask(input logic [1:0] len);
        return {DATA_W{1'b1}} >> (2'd3 - len);
    endfunction

endpackage

// File: rtl/async_tx.sv
module async_tx
    import async_serial_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic [1:0]        cfg_len,
    input  logic [1:0]        cfg_stop,
    input  logic [1:0]        cfg_par,
    input  logic [1:0]        cfg_mult,
    input  logic              wr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              brk_req,
    output logic              ready,
    output logic              txd
);

    tx_state_e         state_q, state_d;
    logic [CNT_W-1:0]  cnt_q, last_tick;
    logic [2:0]        bit_q;
    logic [DATA_W-1:0] hold_q, shift_q;
    logic              hold_full_q, par_q;
    logic              done, par_on, load;

    assign par_on = (cfg_par != PAR_NONE);

    always_comb begin
        if (state_q == T_STOP) last_tick = stop_ticks(cfg_mult, cfg_stop) - 1'b1;
        else                   last_tick = bit_ticks(cfg_mult) - 1'b1;
    end

    assign done = tick && (cnt_q == last_tick);

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            T_IDLE: begin
                if (tick) begin
                    if (brk_req)          state_d = T_BRK;
                    else if (hold_full_q) state_d = T_START;
                end
            end
            T_START: if (done) state_d = T_DATA;
            T_DATA: begin
                if (done && bit_q == last_bit(cfg_len))
                    state_d = par_on ? T_PAR : T_STOP;
            end
            T_PAR:  if (done) state_d = T_STOP;
            T_STOP: begin
                if (done) begin
                    if (brk_req)          state_d = T_BRK;
                    else if (hold_full_q) state_d = T_START;
                    else                  state_d = T_IDLE;
                end
            end
            T_BRK:  if (tick && !brk_req) state_d = T_IDLE;
            default: state_d = T_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= T_IDLE;
        else        state_q <= state_d;
    end

    assign load = (state_d == T_START) && (state_q != T_START);

    // holding register, shift register and bit timing
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hold_q      <= '0;
            hold_full_q <= 1'b0;
            shift_q     <= '0;
            par_q       <= 1'b0;
            bit_q       <= '0;
            cnt_q       <= '0;
        end else begin
            if (wr && !hold_full_q) begin
                hold_q      <= wdata;
                hold_full_q <= 1'b1;
            end else if (load) begin
                hold_full_q <= 1'b0;
            end
            if (load) begin
                shift_q <= hold_q & len_mask(cfg_len);
                par_q   <= (^(hold_q & len_mask(cfg_len))) ^ (cfg_par == PAR_ODD);
                bit_q   <= '0;
            end else if (state_q == T_DATA && done) begin
                shift_q <= shift_q >> 1;
                bit_q   <= bit_q + 3'd1;
            end
            if (tick) begin
                if (done || state_d != state_q || state_q == T_IDLE || state_q == T_BRK)
                    cnt_q <= '0;
                else
                    cnt_q <= cnt_q + 1'b1;
            end
        end
    end

    // outputs
    always_comb begin
        unique case (state_q)
            T_IDLE:  txd = 1'b1;
            T_START: txd = 1'b0;
            T_DATA:  txd = shift_q[0];
            T_PAR:   txd = par_q;
            T_STOP:  txd = 1'b1;
            T_BRK:   txd = 1'b0;
            default: txd = 1'b1;
        endcase
        ready = !hold_full_q;
    end

endmodule

// File: rtl/async_rx.sv
module async_rx
    import async_serial_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick,
    input  logic [1:0] cfg_len,
    input  logic [1:0] cfg_par,
    input  logic [1:0] cfg_mult,
    input  logic       rxd,
    output logic       push,
    output rx_entry_t  entry
);

    rx_state_e         state_q, state_d;
    logic [1:0]        sync_q;
    logic              rx_s;
    logic [CNT_W-1:0]  cnt_q, bt;
    logic [2:0]        bit_q;
    logic [DATA_W-1:0] sh_q, data_w;
    logic              parbit_q, par_on, sample, ferr_w;

    assign rx_s   = sync_q[1];
    assign bt     = bit_ticks(cfg_mult);
    assign par_on = (cfg_par != PAR_NONE);
    assign sample = tick && (cnt_q == bt - 1'b1);
    assign ferr_w = !rx_s;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q <= 2'b11;
        else        sync_q <= {sync_q[0], rxd};
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            R_HUNT: begin
                if (tick && !rx_s)
                    state_d = (cfg_mult == 2'd0) ? R_DATA : R_START;
            end
            R_START: begin
                if (tick && cnt_q == (bt >> 1) - 1'b1)
                    state_d = rx_s ? R_HUNT : R_DATA;
            end
            R_DATA: begin
                if (sample && bit_q == last_bit(cfg_len))
                    state_d = par_on ? R_PAR : R_STOP;
            end
            R_PAR:  if (sample) state_d = R_STOP;
            R_STOP: if (sample) state_d = ferr_w ? R_WAIT : R_HUNT;
            R_WAIT: if (tick && rx_s) state_d = R_HUNT;
            default: state_d = R_HUNT;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= R_HUNT;
        else        state_q <= state_d;
    end

    // sampling datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q    <= '0;
            bit_q    <= '0;
            sh_q     <= '0;
            parbit_q <= 1'b0;
        end else begin
            if (tick) begin
                if (sample || state_d != state_q || state_q == R_HUNT || state_q == R_WAIT)
                    cnt_q <= '0;
                else
                    cnt_q <= cnt_q + 1'b1;
            end
            if (state_q == R_HUNT) begin
                bit_q    <= '0;
                parbit_q <= 1'b0;
            end else if (state_q == R_DATA && sample) begin
                sh_q  <= {rx_s, sh_q[DATA_W-1:1]};
                bit_q <= bit_q + 3'd1;
            end else if (state_q == R_PAR && sample) begin
                parbit_q <= rx_s;
            end
        end
    end

    // outputs
    always_comb begin
        data_w     = sh_q >> (2'd3 - cfg_len);
        push       = (state_q == R_STOP) && sample;
        entry.data = data_w;
        entry.perr = par_on && (parbit_q != ((^data_w) ^ (cfg_par == PAR_ODD)));
        entry.ferr = ferr_w;
        entry.brk  = ferr_w && (data_w == '0) && !(par_on && parbit_q);
        entry.ovr  = 1'b0;
    end

endmodule

// File: rtl/async_rx_fifo.sv
module async_rx_fifo
    import async_serial_pkg::*;
#(
    parameter int DEPTH = 4
) (
    input  logic      clk,
    input  logic      rst_n,
    input  logic      push,
    input  rx_entry_t din,
    input  logic      pop,
    output rx_entry_t dout,
    output logic      valid
);

    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = PW + 1;

    rx_entry_t       mem [DEPTH];
    logic [PW-1:0]   wr_ptr, rd_ptr, prev_ptr;
    logic [CW-1:0]   count;
    logic            full, empty, do_pop, do_push, ovr;

    assign full     = (count == CW'(DEPTH));
    assign empty    = (count == '0);
    assign do_pop   = pop && !empty;
    assign do_push  = push && (!full || do_pop);
    assign ovr      = push && full && !do_pop;
    assign prev_ptr = (wr_ptr == '0) ? PW'(DEPTH - 1) : wr_ptr - 1'b1;

    function automatic logic [PW-1:0] nxt(input logic [PW-1:0] p);
        return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (do_push) wr_ptr <= nxt(wr_ptr);
            if (do_pop)  rd_ptr <= nxt(rd_ptr);
            if (do_push && !do_pop)      count <= count + 1'b1;
            else if (do_pop && !do_push) count <= count - 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (do_push)  mem[wr_ptr]       <= din;
        else if (ovr) mem[prev_ptr].ovr <= 1'b1;
    end

    assign dout  = mem[rd_ptr];
    assign valid = !empty;

endmodule

// File: rtl/async_serial_chan.sv
module async_serial_chan
    import async_serial_pkg::*;
#(
    parameter int RX_DEPTH = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       sclk_en,
    input  logic [1:0] cfg_len,
    input  logic [1:0] cfg_stop,
    input  logic [1:0] cfg_par,
    input  logic [1:0] cfg_mult,
    input  logic [7:0] tx_data,
    input  logic       tx_wr,
    input  logic       tx_break,
    output logic       tx_ready,
    output logic       txd,
    input  logic       rxd,
    input  logic       rx_rd,
    output logic       rx_valid,
    output logic [7:0] rx_data,
    output logic       rx_perr,
    output logic       rx_ferr,
    output logic       rx_ovr,
    output logic       rx_brk
);

    rx_entry_t rx_new, rx_head;
    logic      rx_push;

    async_tx u_tx (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (sclk_en),
        .cfg_len  (cfg_len),
        .cfg_stop (cfg_stop),
        .cfg_par  (cfg_par),
        .cfg_mult (cfg_mult),
        .wr       (tx_wr),
        .wdata    (tx_data),
        .brk_req  (tx_break),
        .ready    (tx_ready),
        .txd      (txd)
    );

    async_rx u_rx (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (sclk_en),
        .cfg_len  (cfg_len),
        .cfg_par  (cfg_par),
        .cfg_mult (cfg_mult),
        .rxd      (rxd),
        .push     (rx_push),
        .entry    (rx_new)
    );

    async_rx_fifo #(.DEPTH(RX_DEPTH)) u_fifo (
        .clk   (clk),
        .rst_n (rst_n),
        .push  (rx_push),
        .din   (rx_new),
        .pop   (rx_rd),
        .dout  (rx_head),
        .valid (rx_valid)
    );

    assign rx_data = rx_head.data;
    assign rx_perr = rx_head.perr;
    assign rx_ferr = rx_head.ferr;
    assign rx_ovr  = rx_head.ovr;
    assign rx_brk  = rx_head.brk;

endmodule

// File: rtl/async_serial_chk.sv
module async_serial_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       sclk_en,
    input logic       tx_wr,
    input logic       tx_ready,
    input logic       txd,
    input logic       rx_rd,
    input logic       rx_valid,
    input logic [7:0] rx_data,
    input logic       rx_ferr,
    input logic       rx_brk
);

    AST_HOLD_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_wr && tx_ready) |=> !tx_ready); // R6

    AST_READY_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tx_ready) |-> $past(sclk_en)); // R6

    AST_TXD_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        !sclk_en |=> $stable(txd)); // R2

    AST_HEAD_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid && !rx_rd) |=> (rx_valid && $stable(rx_data))); // R10

    AST_BRK_CHAR: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid && rx_brk) |-> ((rx_data == 8'h00) && rx_ferr)); // R12

endmodule

bind async_serial_chan async_serial_chk u_chk (.*);

// File: tb/sim_async_serial_chan.sv
`timescale 1ns/1ps
module sim_async_serial_chan;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sclk_en = 1'b0;
    logic [1:0] cfg_len = 2'd3, cfg_stop = 2'd0, cfg_par = 2'd0, cfg_mult = 2'd0;
    logic [7:0] tx_data = 8'h00;
    logic       tx_wr = 1'b0, tx_break = 1'b0, rxd = 1'b1, rx_rd = 1'b0;
    logic       tx_ready, txd, rx_valid, rx_perr, rx_ferr, rx_ovr, rx_brk;
    logic [7:0] rx_data;

    int tests = 0;
    int fails = 0;

    always #2 clk = ~clk;
    always @(negedge clk) sclk_en <= ~sclk_en;

    async_serial_chan u0 (
        .clk(clk), .rst_n(rst_n), .sclk_en(sclk_en),
        .cfg_len(cfg_len), .cfg_stop(cfg_stop), .cfg_par(cfg_par), .cfg_mult(cfg_mult),
        .tx_data(tx_data), .tx_wr(tx_wr), .tx_break(tx_break),
        .tx_ready(tx_ready), .txd(txd), .rxd(rxd), .rx_rd(rx_rd),
        .rx_valid(rx_valid), .rx_data(rx_data), .rx_perr(rx_perr),
        .rx_ferr(rx_ferr), .rx_ovr(rx_ovr), .rx_brk(rx_brk)
    );

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic int ticks_of(input logic [1:0] m);
        return (m == 2'd0) ? 1 : (m == 2'd1) ? 16 : (m == 2'd2) ? 32 : 64;
    endfunction

    function automatic logic [7:0] mask_of(input int len);
        return 8'hFF >> (8 - len);
    endfunction

    function automatic logic par_of(input logic [7:0] v, input int len, input logic [1:0] p);
        return (^(v & mask_of(len))) ^ (p == 2'd2);
    endfunction

    task automatic set_cfg(input int len, input logic [1:0] stop,
                           input logic [1:0] par, input logic [1:0] mult);
        @(negedge clk);
        cfg_len = 2'(len - 5); cfg_stop = stop; cfg_par = par; cfg_mult = mult;
        @(negedge clk);
    endtask

    task automatic tx_write(input logic [7:0] v);
        while (tx_ready !== 1'b1) @(negedge clk);
        tx_data = v; tx_wr = 1'b1;
        @(negedge clk);
        tx_wr = 1'b0;
    endtask

    task automatic tx_grab(input int n, input int len, input bit pon,
                           output logic [7:0] d, output logic pb,
                           output logic st0, output logic stp);
        d = 8'h00; pb = 1'b0;
        while (txd !== 1'b0) @(negedge clk);
        repeat (n) @(negedge clk);
        st0 = txd;
        for (int i = 0; i < len; i++) begin
            repeat (2 * n) @(negedge clk);
            d[i] = txd;
        end
        if (pon) begin
            repeat (2 * n) @(negedge clk);
            pb = txd;
        end
        repeat (2 * n) @(negedge clk);
        stp = txd;
    endtask

    // R2 R3 R5: one transmitted frame in a given format
    task automatic t_tx_frame(input logic [7:0] v, input int len,
                              input logic [1:0] par, input logic [1:0] mult);
        logic [7:0] d; logic pb, st0, stp;
        set_cfg(len, 2'd0, par, mult);
        fork
            tx_grab(ticks_of(mult), len, par != 2'd0, d, pb, st0, stp);
            tx_write(v);
        join
        chk("R2", "start bit", st0, 1'b0);
        chk("R2", "data LSB first", d, v & mask_of(len));
        chk("R2", "stop bit", stp, 1'b1);
        if (par != 2'd0) chk("R3", "tx parity", pb, par_of(v, len, par));
        repeat (4 * ticks_of(mult)) @(negedge clk);
    endtask

    // R4: exact high gap between back-to-back all-zero frames
    task automatic t_stop_gap(input logic [1:0] stop, input logic [1:0] mult, input int exp);
        int gap;
        set_cfg(8, stop, 2'd0, mult);
        gap = 0;
        fork
            begin
                while (txd !== 1'b0) @(negedge clk);
                while (txd !== 1'b1) @(negedge clk);
                while (txd === 1'b1) begin gap++; @(negedge clk); end
            end
            begin tx_write(8'h00); tx_write(8'h00); end
        join
        chk("R4", "stop gap clocks", gap, exp);
        repeat (40 * ticks_of(mult)) @(negedge clk);
    endtask

    // R6: double buffering and ignored writes
    task automatic t_tx_buffer();
        logic [7:0] da, db; logic pb, s0, sp, s0b, spb;
        int lows;
        set_cfg(8, 2'd0, 2'd0, 2'd0);
        fork
            begin
                tx_grab(1, 8, 1'b0, da, pb, s0, sp);
                tx_grab(1, 8, 1'b0, db, pb, s0b, spb);
            end
            begin
                tx_write(8'hC3);
                chk("R6", "ready low after write", tx_ready, 1'b0);
                tx_data = 8'hEE; tx_wr = 1'b1;
                @(negedge clk);
                tx_wr = 1'b0;
                tx_write(8'h3A);
            end
        join
        chk("R6", "first byte", da, 8'hC3);
        chk("R6", "second byte", db, 8'h3A);
        lows = 0;
        repeat (40) begin @(negedge clk); if (txd !== 1'b1) lows++; end
        chk("R6", "ignored write not sent", lows, 0);
        chk("R6", "ready after drain", tx_ready, 1'b1);
    endtask

    // R13: transmit break
    task automatic t_tx_break();
        int highs;
        set_cfg(8, 2'd0, 2'd0, 2'd0);
        tx_break = 1'b1;
        repeat (3) @(negedge clk);
        highs = 0;
        repeat (20) begin @(negedge clk); if (txd !== 1'b0) highs++; end
        chk("R13", "line held low", highs, 0);
        tx_break = 1'b0;
        repeat (4) @(negedge clk);
        chk("R13", "line high after release", txd, 1'b1);
    endtask

    task automatic send_rx(input logic [7:0] v, input int len, input logic [1:0] par,
                           input int n, input bit bad_par, input bit bad_stop);
        rxd = 1'b0;
        repeat (2 * n) @(negedge clk);
        for (int i = 0; i < len; i++) begin
            rxd = v[i];
            repeat (2 * n) @(negedge clk);
        end
        if (par != 2'd0) begin
            rxd = par_of(v, len, par) ^ bad_par;
            repeat (2 * n) @(negedge clk);
        end
        rxd = !bad_stop;
        repeat (2 * n) @(negedge clk);
        rxd = 1'b1;
        repeat (4 * n) @(negedge clk);
    endtask

    task automatic read_rx(input string req, input logic [7:0] exp_d,
                           input logic pe, input logic fe, input logic ov, input logic bk);
        chk(req, "rx_valid", rx_valid, 1'b1);
        chk(req, "rx_data", rx_data, exp_d);
        chk(req, "flags perr/ferr/ovr/brk", {rx_perr, rx_ferr, rx_ovr, rx_brk}, {pe, fe, ov, bk});
        rx_rd = 1'b1;
        @(negedge clk);
        rx_rd = 1'b0;
        @(negedge clk);
    endtask

    // R5 R8 R3: clean received frames in several formats
    task automatic t_rx_clean(input logic [7:0] v, input int len,
                              input logic [1:0] par, input logic [1:0] mult);
        set_cfg(len, 2'd0, par, mult);
        send_rx(v, len, par, ticks_of(mult), 1'b0, 1'b0);
        read_rx("R8", v & mask_of(len), 1'b0, 1'b0, 1'b0, 1'b0);
        chk("R10", "queue empty after read", rx_valid, 1'b0);
    endtask

    // R3 R9: error flags
    task automatic t_rx_errors();
        set_cfg(8, 2'd0, 2'd1, 2'd1);
        send_rx(8'h37, 8, 2'd1, 16, 1'b1, 1'b0);
        read_rx("R3", 8'h37, 1'b1, 1'b0, 1'b0, 1'b0);
        set_cfg(8, 2'd0, 2'd0, 2'd1);
        send_rx(8'h81, 8, 2'd0, 16, 1'b0, 1'b1);
        read_rx("R9", 8'h81, 1'b0, 1'b1, 1'b0, 1'b0);
        chk("R9", "no spurious entry", rx_valid, 1'b0);
        send_rx(8'h24, 8, 2'd0, 16, 1'b0, 1'b0);
        read_rx("R9", 8'h24, 1'b0, 1'b0, 1'b0, 1'b0);
    endtask

    // R7: glitch rejection
    task automatic t_rx_glitch();
        set_cfg(8, 2'd0, 2'd0, 2'd1);
        rxd = 1'b0;
        repeat (4) @(negedge clk);
        rxd = 1'b1;
        repeat (12 * 32) @(negedge clk);
        chk("R7", "glitch ignored", rx_valid, 1'b0);
        send_rx(8'h96, 8, 2'd0, 16, 1'b0, 1'b0);
        read_rx("R7", 8'h96, 1'b0, 1'b0, 1'b0, 1'b0);
    endtask

    // R12: incoming break
    task automatic t_rx_break();
        set_cfg(8, 2'd0, 2'd0, 2'd1);
        rxd = 1'b0;
        repeat (12 * 32) @(negedge clk);
        rxd = 1'b1;
        repeat (64) @(negedge clk);
        read_rx("R12", 8'h00, 1'b0, 1'b1, 1'b0, 1'b1);
        chk("R12", "break reported once", rx_valid, 1'b0);
        send_rx(8'h42, 8, 2'd0, 16, 1'b0, 1'b0);
        read_rx("R12", 8'h42, 1'b0, 1'b0, 1'b0, 1'b0);
    endtask

    // R10 R11: queue depth and overrun
    task automatic t_rx_overrun();
        set_cfg(8, 2'd0, 2'd0, 2'd0);
        for (int i = 1; i <= 5; i++) send_rx(8'(i * 17), 8, 2'd0, 1, 1'b0, 1'b0);
        read_rx("R10", 8'h11, 1'b0, 1'b0, 1'b0, 1'b0);
        read_rx("R10", 8'h22, 1'b0, 1'b0, 1'b0, 1'b0);
        read_rx("R10", 8'h33, 1'b0, 1'b0, 1'b0, 1'b0);
        read_rx("R11", 8'h44, 1'b0, 1'b0, 1'b1, 1'b0);
        chk("R11", "fifth character discarded", rx_valid, 1'b0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        tests++; fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        chk("R1", "txd in reset", txd, 1'b1);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk("R1", "txd idle", txd, 1'b1);
        chk("R1", "tx_ready", tx_ready, 1'b1);
        chk("R1", "rx_valid", rx_valid, 1'b0);

        t_tx_frame(8'hA5, 8, 2'd0, 2'd0);
        t_tx_frame(8'hDB, 7, 2'd1, 2'd1);
        t_tx_frame(8'h13, 5, 2'd2, 2'd2);
        t_stop_gap(2'd0, 2'd1, 32);
        t_stop_gap(2'd1, 2'd1, 48);
        t_stop_gap(2'd2, 2'd1, 64);
        t_stop_gap(2'd1, 2'd0, 4);
        t_tx_buffer();
        t_tx_break();

        t_rx_clean(8'h3C, 8, 2'd0, 2'd1);
        t_rx_clean(8'h55, 7, 2'd1, 2'd2);
        t_rx_clean(8'hFF, 5, 2'd2, 2'd3);
        t_rx_errors();
        t_rx_glitch();
        t_rx_break();
        t_rx_overrun();

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule